// File: doc/BRIEF.md
# Temperature Compensation Trim Controller

This block produces the code for a DAC that trims the load capacitance of a crystal oscillator. It takes a signed temperature code in sixteenth-degree steps and looks up two neighbouring trim codes in a table laid out on a half-degree grid. It blends the two entries linearly according to the three low temperature bits and then adds a signed frequency-tuning offset. The saturated result goes to the DAC output register, and a one-cycle strobe marks each new value.

Work happens only when there is something new. A new temperature reading that differs from the held one starts a recomputation, and so does a tuning write that changes the tuning word. A trigger that arrives while a computation is in flight is remembered and served as soon as the datapath is free. A freeze input stops temperature readings from being taken, so the temperature term stays fixed, while tuning changes still produce fresh DAC codes. The trim table is a synchronous single-port-read memory with its own write port for loading.

Top module: `tcomp_trim_ctrl`

## Requirements
- R1: While `rst` is high, `dac_code` is 0 and `dac_load` is 0. After `rst` falls, the block performs exactly one computation for temperature code 400 (+25 °C) and tuning word 0.
- R2: For codes T strictly between -640 and 1360, the lower table entry is (T+640)>>3 and the fraction f is the low 3 bits of (T+640). Entry k stands for -40 °C + k·0.5 °C, and the upper entry is the lower entry plus 1.
- R3: The interpolated trim equals floor((lo·(8-f) + hi·f)/8), where lo and hi are the 16-bit unsigned lower and upper entries.
- R4: A code at or below -640 uses entry 0 alone, and a code at or above 1360 uses entry 250 alone (fraction 0).
- R5: The 14-bit two's-complement tuning word is added to the trim, with bit 13 as the sign.
- R6: The sum saturates to 0 when negative and to 65535 when above 65535; it never wraps.
- R7: A computation starts on a `temp_valid` reading whose code differs from the held temperature, or on a `tune_we` write whose word differs from the held tuning word. A reading or write that matches the held value gives no `dac_load`.
- R8: While `freeze` is 1, `temp_valid` readings are ignored and the held temperature is kept. A changed tuning write still recomputes, using the held temperature.
- R9: `dac_load` is high for one cycle per computation, and `dac_code` changes only in a cycle where `dac_load` is high.
- R10: Any number of triggers that arrive during a computation produce exactly one further computation, and that computation uses the latest temperature and tuning values.
- R11: Table writes through `tbl_we` can happen at any time, including during reset. They start no computation, and the next computation uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | New temperature reading present |
| temp_code | input | 12 | Signed temperature, 0.0625 °C per LSB |
| tune_we | input | 1 | Tuning word write strobe |
| tune_word | input | 14 | Signed frequency-tuning offset |
| freeze | input | 1 | Hold the temperature term |
| tbl_we | input | 1 | Trim table write enable |
| tbl_waddr | input | 8 | Trim table write index |
| tbl_wdata | input | 16 | Trim table write data |
| dac_code | output | 16 | Registered DAC code |
| dac_load | output | 1 | One-cycle strobe marking a new DAC code |

## Verification
The bench checks temperatures at the grid edges: exactly -640, one below it, 1359 and exactly 1360. An off-by-one in the clamp there would fetch past the table or blend with a stray neighbour. It also drives sums far past both rails, where a design that wraps would show a small code instead of 0 or 65535. Three tuning writes land back to back during a computation; a design that drops the queued trigger would miss the final value, and one that counts triggers would load too often. The bench also checks frozen readings, repeated equal values and table writes, each of which must leave `dac_load` quiet.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_INTERP,
    ST_SUM,
    ST_LOAD
  } tc_state_e;
endpackage

// File: rtl/tcomp_trim_ram.sv
module tcomp_trim_ram #(
  parameter int DEPTH = 251,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcomp_index.sv
module tcomp_index #(
  parameter int TEMP_W    = 12,
  parameter int IDX_W     = 8,
  parameter int FRAC_BITS = 3,
  parameter int TMIN      = -640,
  parameter int TMAX      = 1360,
  parameter int LAST      = 250
) (
  input  logic signed [TEMP_W-1:0]  temp,
  output logic [IDX_W-1:0]          idx_lo,
  output logic [IDX_W-1:0]          idx_hi,
  output logic [FRAC_BITS-1:0]      frac
);
  int t_int;
  int off_int;

  always_comb begin
    t_int   = int'(temp);
    off_int = t_int - TMIN;
    if (t_int <= TMIN) begin
      idx_lo = '0;
      frac   = '0;
    end else if (t_int >= TMAX) begin
      idx_lo = IDX_W'(LAST);
      frac   = '0;
    end else begin
      idx_lo = IDX_W'(off_int >>> FRAC_BITS);
      frac   = FRAC_BITS'(off_int);
    end
    idx_hi = (idx_lo == IDX_W'(LAST)) ? idx_lo : idx_lo + 1'b1;
  end
endmodule

// File: rtl/tcomp_interp.sv
module tcomp_interp #(
  parameter int DW        = 16,
  parameter int FRAC_BITS = 3
) (
  input  logic [DW-1:0]        lo,
  input  logic [DW-1:0]        hi,
  input  logic [FRAC_BITS-1:0] frac,
  output logic [DW-1:0]        trim
);
  localparam int STEPS = 1 << FRAC_BITS;
  localparam int ACCW  = DW + FRAC_BITS;

  logic [ACCW-1:0] acc;

  always_comb begin
    acc  = ACCW'(lo) * ACCW'(STEPS - int'(frac)) + ACCW'(hi) * ACCW'(frac);
    trim = DW'(acc >> FRAC_BITS);
  end
endmodule

// File: rtl/tcomp_sat_add.sv
module tcomp_sat_add #(
  parameter int DW     = 16,
  parameter int TUNE_W = 14
) (
  input  logic [DW-1:0]            trim,
  input  logic signed [TUNE_W-1:0] tune,
  output logic [DW-1:0]            sum
);
  localparam int SW = DW + 2;

  logic signed [SW-1:0] s;
  logic signed [SW-1:0] top_val;

  always_comb begin
    top_val = $signed({2'b00, {DW{1'b1}}});
    s       = $signed({2'b00, trim}) + SW'(tune);
    if (s < 0)            sum = '0;
    else if (s > top_val) sum = {DW{1'b1}};
    else                  sum = s[DW-1:0];
  end
endmodule

// File: rtl/tcomp_trim_ctrl.sv
module tcomp_trim_ctrl
  import tcomp_pkg::*;
#(
  parameter int TEMP_W     = 12,
  parameter int TUNE_W     = 14,
  parameter int CODE_W     = 16,
  parameter int FRAC_BITS  = 3,
  parameter int TMIN       = -640,
  parameter int TMAX       = 1360,
  parameter int RESET_TEMP = 400,
  localparam int ENTRIES   = ((TMAX - TMIN) >> FRAC_BITS) + 1,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     temp_valid,
  input  logic signed [TEMP_W-1:0] temp_code,
  input  logic                     tune_we,
  input  logic signed [TUNE_W-1:0] tune_word,
  input  logic                     freeze,
  input  logic                     tbl_we,
  input  logic [IDX_W-1:0]         tbl_waddr,
  input  logic [CODE_W-1:0]        tbl_wdata,
  output logic [CODE_W-1:0]        dac_code,
  output logic                     dac_load
);
  localparam int LAST = ENTRIES - 1;

  tc_state_e                state;
  logic signed [TEMP_W-1:0] cur_temp;
  logic signed [TUNE_W-1:0] tune_reg;
  logic signed [TEMP_W-1:0] snap_temp;
  logic signed [TUNE_W-1:0] snap_tune;
  logic                     pend;
  logic [CODE_W-1:0]        lo_q;
  logic [CODE_W-1:0]        trim_q;
  logic [CODE_W-1:0]        sum_q;

  logic [IDX_W-1:0]         idx_lo;
  logic [IDX_W-1:0]         idx_hi;
  logic [FRAC_BITS-1:0]     frac;
  logic [IDX_W-1:0]         raddr;
  logic [CODE_W-1:0]        rdata;
  logic [CODE_W-1:0]        trim_c;
  logic [CODE_W-1:0]        sum_c;
  logic                     temp_trig;
  logic                     tune_trig;

  assign temp_trig = temp_valid && !freeze && (temp_code != cur_temp);
  assign tune_trig = tune_we && (tune_word != tune_reg);
  assign raddr     = (state == ST_FETCH_HI) ? idx_hi : idx_lo;

  tcomp_index #(
    .TEMP_W(TEMP_W), .IDX_W(IDX_W), .FRAC_BITS(FRAC_BITS),
    .TMIN(TMIN), .TMAX(TMAX), .LAST(LAST)
  ) u_index (
    .temp(snap_temp), .idx_lo(idx_lo), .idx_hi(idx_hi), .frac(frac)
  );

  tcomp_trim_ram #(.DEPTH(ENTRIES), .AW(IDX_W), .DW(CODE_W)) u_ram (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  tcomp_interp #(.DW(CODE_W), .FRAC_BITS(FRAC_BITS)) u_interp (
    .lo(lo_q), .hi(rdata), .frac(frac), .trim(trim_c)
  );

  tcomp_sat_add #(.DW(CODE_W), .TUNE_W(TUNE_W)) u_sum (
    .trim(trim_q), .tune(snap_tune), .sum(sum_c)
  );

  // Held operating point and pending trigger
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_temp <= TEMP_W'(RESET_TEMP);
      tune_reg <= '0;
      pend     <= 1'b1;
    end else begin
      if (temp_valid && !freeze) cur_temp <= temp_code;
      if (tune_we)               tune_reg <= tune_word;
      if (temp_trig || tune_trig)  pend <= 1'b1;
      else if (state == ST_IDLE)   pend <= 1'b0;
    end
  end

  // Datapath sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      snap_temp <= TEMP_W'(RESET_TEMP);
      snap_tune <= '0;
      lo_q      <= '0;
      trim_q    <= '0;
      sum_q     <= '0;
      dac_code  <= '0;
      dac_load  <= 1'b0;
    end else begin
      dac_load <= 1'b0;
      case (state)
        ST_IDLE: if (pend) begin
          snap_temp <= cur_temp;
          snap_tune <= tune_reg;
          state     <= ST_FETCH_LO;
        end
        ST_FETCH_LO: state <= ST_FETCH_HI;
        ST_FETCH_HI: begin
          lo_q  <= rdata;
          state <= ST_INTERP;
        end
        ST_INTERP: begin
          trim_q <= trim_c;
          state  <= ST_SUM;
        end
        ST_SUM: begin
          sum_q <= sum_c;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          dac_code <= sum_q;
          dac_load <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: strobe lasts one cycle
  a_r9_load_pulse: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load);

  // R9: output only moves with the strobe
  a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
    !dac_load |-> $stable(dac_code));

  // R8: frozen readings leave the held temperature alone
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    freeze |=> cur_temp == $past(cur_temp));

  // R3: blend lies between the two fetched entries
  a_r3_interp_bounds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INTERP) |->
      ((trim_c >= lo_q && trim_c <= rdata) || (trim_c <= lo_q && trim_c >= rdata)));

  // R4: indices stay inside the table
  a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
    (idx_lo <= IDX_W'(LAST)) && ((idx_hi == idx_lo) || (idx_hi == idx_lo + 1'b1)));

  // R6: positive offset never lowers the code, negative never raises it
  a_r6_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && !snap_tune[TUNE_W-1]) |-> sum_q >= trim_q);
  a_r6_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && snap_tune[TUNE_W-1]) |-> sum_q <= trim_q);

  // R10: a trigger seen while busy stays pending
  a_r10_pend_kept: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && (temp_trig || tune_trig)) |=> pend);
endmodule

// File: tb/tb_tcomp_trim_ctrl.sv
module tb_tcomp_trim_ctrl;
  localparam int ENT  = 251;
  localparam int NVEC = 11;
  localparam int VT [NVEC] = '{-600, -593, 0, 3, 1001, 1359, -640, -641, 1360, 2047, -2048};
  localparam int VU [NVEC] = '{0, 25, 25, -300, -300, 8191, -8192, 0, 0, 100, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic temp_valid = 1'b0;
  logic signed [11:0] temp_code = '0;
  logic tune_we = 1'b0;
  logic signed [13:0] tune_word = '0;
  logic freeze = 1'b0;
  logic tbl_we = 1'b0;
  logic [7:0] tbl_waddr = '0;
  logic [15:0] tbl_wdata = '0;
  logic [15:0] dac_code;
  logic dac_load;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  int tb_tbl [ENT];
  int m_temp = 400;
  int m_tune = 0;

  always #2 clk = ~clk;

  tcomp_trim_ctrl dut (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_code(temp_code),
    .tune_we(tune_we), .tune_word(tune_word), .freeze(freeze),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .dac_code(dac_code), .dac_load(dac_load)
  );

  function automatic int tbl_init(int k);
    if (k == 0) return 5;
    if (k == ENT - 1) return 65530;
    return 20000 + k * 97 + ((k * k * 13) % 700);
  endfunction

  function automatic int model(int t, int u);
    int idx, f, lo, hi, trim, s;
    if (t <= -640) begin idx = 0; f = 0; end
    else if (t >= 1360) begin idx = ENT - 1; f = 0; end
    else begin idx = (t + 640) / 8; f = (t + 640) % 8; end
    lo = tb_tbl[idx];
    hi = tb_tbl[(idx == ENT - 1) ? idx : idx + 1];
    trim = (lo * (8 - f) + hi * f) / 8;
    s = trim + u;
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_load(output bit got, output int code);
    got = 1'b0;
    code = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dac_load) begin got = 1'b1; code = int'(dac_code); return; end
    end
  endtask

  task automatic expect_load(string tag, int exp);
    bit got;
    int code;
    wait_load(got, code);
    check({tag, " load seen"}, int'(got), 1);
    if (got) check({tag, " dac_code"}, code, exp);
  endtask

  task automatic expect_quiet(string tag);
    int pulses = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dac_load) pulses++;
    end
    check({tag, " no load"}, pulses, 0);
  endtask

  task automatic apply(int t, int u, bit do_t, bit do_u);
    @(negedge clk);
    temp_valid = do_t; temp_code = 12'(t);
    tune_we = do_u;    tune_word = 14'(u);
    @(negedge clk);
    temp_valid = 1'b0; tune_we = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < ENT; k++) tb_tbl[k] = tbl_init(k);
    // R11: load the table while reset is held
    for (int k = 0; k < ENT; k++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_waddr = 8'(k); tbl_wdata = 16'(tb_tbl[k]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
    check("R1 reset dac_code", int'(dac_code), 0);
    check("R1 reset dac_load", int'(dac_load), 0);
    rst = 1'b0;
    expect_load("R1 first computation at +25C", model(400, 0));

    // R2 R3 R4 R5 R6: vector walk
    for (int v = 0; v < NVEC; v++) begin
      bit dt, du;
      dt = (VT[v] != m_temp);
      du = (VU[v] != m_tune);
      m_temp = VT[v];
      m_tune = VU[v];
      apply(VT[v], VU[v], dt, du);
      expect_load($sformatf("R2/R3/R4/R5/R6 vector %0d", v), model(m_temp, m_tune));
    end

    // R7: equal values start nothing
    apply(m_temp, 0, 1'b1, 1'b0);
    expect_quiet("R7 same temperature");
    apply(0, m_tune, 1'b0, 1'b1);
    expect_quiet("R7 same tuning word");

    // R11: table write alone is quiet, then used
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 8'd0; tbl_wdata = 16'd3000;
    @(negedge clk);
    tbl_we = 1'b0;
    tb_tbl[0] = 3000;
    expect_quiet("R11 table write");
    m_tune = -7;
    apply(0, m_tune, 1'b0, 1'b1);
    expect_load("R11 new entry used", model(m_temp, m_tune));

    // Move to a mid-range point
    m_temp = 805; m_tune = 40;
    apply(m_temp, m_tune, 1'b1, 1'b1);
    expect_load("R5 mid point", model(m_temp, m_tune));

    // R8: freeze
    @(negedge clk);
    freeze = 1'b1;
    apply(200, 0, 1'b1, 1'b0);
    expect_quiet("R8 frozen reading");
    m_tune = 77;
    apply(0, m_tune, 1'b0, 1'b1);
    expect_load("R8 tune while frozen uses held temp", model(805, 77));
    @(negedge clk);
    freeze = 1'b0;
    m_temp = 200;
    apply(m_temp, 0, 1'b1, 1'b0);
    expect_load("R8 reading after unfreeze", model(200, 77));

    // R10: three writes back to back, one extra computation
    @(negedge clk);
    tune_we = 1'b1; tune_word = 14'sd100;
    @(negedge clk);
    tune_word = 14'sd200;
    @(negedge clk);
    tune_word = -14'sd300;
    @(negedge clk);
    tune_we = 1'b0;
    m_tune = -300;
    expect_load("R10 first of burst", model(200, 100));
    expect_load("R10 latest of burst", model(200, -300));
    expect_quiet("R10 no third computation");

    // R9: strobe width
    apply(-100, 0, 1'b1, 1'b0);
    begin
      bit got;
      int code;
      wait_load(got, code);
      check("R9 load seen", int'(got), 1);
      check("R9 code", code, model(-100, -300));
      @(negedge clk);
      check("R9 strobe one cycle", int'(dac_load), 0);
      check("R9 code holds", int'(dac_code), model(-100, -300));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule